// File: doc/BRIEF.md
# Energy Pulse Width Limiter

This block converts single-cycle energy events from a metering computation engine into active-low output pulses. In the normal mode, each event pulls the output low. The output stays low for a programmable number of time-base units, (2·N+1), where N is the configured maximum-width value.

The time-base unit is chosen by the interval setting. An interval of zero uses the raw sample tick. A nonzero interval K uses a divided tick, one for every K sample ticks. Events are never queued in a FIFO; a pulse starts as soon as its event arrives.

When N is at its all-ones value, width limiting is switched off. Each event then toggles the output, so consecutive events mark out alternating low and high halves of a 50% duty waveform.

An event that arrives while a pulse is active is held in a single pending slot. It starts the next pulse one cycle after the current one ends. The configuration is written through one strobe that loads both values together.

Top module: `epulse_limiter`

## Requirements
- R1: After reset the output is high, the maximum-width value is 255 and the interval is 0. As a result, the first event drives the output low and it stays low until a second event arrives, whatever ticks occur.
- R2: A cycle with `cfg_we_i` high loads both configuration values. It also cancels any active pulse and any held event, so the output is high in the next cycle. The interval divider restarts its count.
- R3: In limited mode (maximum width not 255), an event arriving while no pulse is active drives the output low in the next cycle.
- R4: A limited pulse returns high in the cycle after the (2·N+1)-th time-base tick. Only ticks that come after the cycle in which the pulse started are counted; a tick in the start cycle itself is not counted.
- R5: With interval 0, every sample tick is one time-base tick.
- R6: With interval K ≠ 0, a time-base tick occurs on every K-th sample tick, counted from the last configuration write or reset.
- R7: An event that arrives while a limited pulse is active, including the pulse's last cycle, is held. The output is then high for exactly one cycle after the pulse ends and goes low again in the following cycle.
- R8: Only one event is held. Further events during the same pulse are dropped, so only one extra pulse follows.
- R9: With maximum width 255, every event toggles the output in the next cycle. Time-base ticks have no effect on the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| evt_i | input | 1 | Single-cycle energy event strobe |
| samp_tick_i | input | 1 | Single-cycle sample-period tick |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_maxw_i | input | 8 | Maximum-width value N (255 selects 50% mode) |
| cfg_intv_i | input | 8 | Interval value K (0 selects the sample tick) |
| pulse_no | output | 1 | Active-low energy pulse |

## Verification
A wrong count load or a wrong decrement shows up as a pulse edge that is early or late by one or more time-base units. It becomes visible at the first pulse end after the fault. A divider fault stretches or shrinks pulses by whole sample ticks once the interval is nonzero. A lost or duplicated held event shows within two cycles of a pulse end, as a missing or extra low pulse. A broken mode decode shows on the next event as a toggle where a bounded pulse was expected, or the reverse.

// File: rtl/epl_pkg.sv
package epl_pkg;
  typedef enum logic {
    MODE_LIMIT = 1'b0,
    MODE_HALF  = 1'b1
  } epl_mode_e;
endpackage

// File: rtl/epl_cfg_regs.sv
module epl_cfg_regs
  import epl_pkg::*;
#(
  parameter int MAXW_W = 8,
  parameter int INTV_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [MAXW_W-1:0] maxw_i,
  input  logic [INTV_W-1:0] intv_i,
  output logic [MAXW_W-1:0] maxw_o,
  output logic [INTV_W-1:0] intv_o,
  output epl_mode_e         mode_o
);
  localparam logic [MAXW_W-1:0] MAXW_RST = '1;
  localparam logic [INTV_W-1:0] INTV_RST = '0;

  // all-ones width value turns the limiter into a toggle
  function automatic epl_mode_e decode_mode(input logic [MAXW_W-1:0] n);
    return (n == MAXW_RST) ? MODE_HALF : MODE_LIMIT;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      maxw_o <= MAXW_RST;
      intv_o <= INTV_RST;
    end else if (we_i) begin
      maxw_o <= maxw_i;
      intv_o <= intv_i;
    end
  end

  assign mode_o = decode_mode(maxw_o);
endmodule

// File: rtl/epl_timebase.sv
module epl_timebase #(
  parameter int INTV_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              restart_i,
  input  logic              samp_tick_i,
  input  logic [INTV_W-1:0] intv_i,
  output logic              ti_tick_o
);
  logic [INTV_W-1:0] div_q;
  logic              bypass;
  logic              wrap;

  // last position of a K-long divide cycle
  function automatic logic at_wrap(input logic [INTV_W-1:0] pos,
                                   input logic [INTV_W-1:0] k);
    return pos >= (k - 1'b1);
  endfunction

  assign bypass    = (intv_i == '0);
  assign wrap      = at_wrap(div_q, intv_i);
  assign ti_tick_o = samp_tick_i && (bypass || wrap);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q <= '0;
    end else if (restart_i) begin
      div_q <= '0;
    end else if (samp_tick_i && !bypass) begin
      div_q <= wrap ? '0 : div_q + 1'b1;
    end
  end
endmodule

// File: rtl/epl_pulse_ctrl.sv
module epl_pulse_ctrl
  import epl_pkg::*;
#(
  parameter int MAXW_W = 8,
  parameter int CNT_W  = MAXW_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              evt_i,
  input  logic              ti_tick_i,
  input  epl_mode_e         mode_i,
  input  logic [MAXW_W-1:0] maxw_i,
  output logic              active_o,
  output logic              pend_o,
  output logic [CNT_W-1:0]  cnt_o,
  output logic [CNT_W-1:0]  load_o,
  output logic              start_o,
  output logic              fin_o
);
  logic             act_q;
  logic             pend_q;
  logic [CNT_W-1:0] cnt_q;
  logic             limit;

  // bounded width in time-base units: 2N+1
  function automatic logic [CNT_W-1:0] width_units(input logic [MAXW_W-1:0] n);
    return {n, 1'b1};
  endfunction

  assign limit   = (mode_i == MODE_LIMIT);
  assign load_o  = width_units(maxw_i);
  assign start_o = !clr_i && limit && !act_q && (evt_i || pend_q);
  assign fin_o   = !clr_i && limit && act_q && ti_tick_i && (cnt_q == CNT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q  <= 1'b0;
      pend_q <= 1'b0;
      cnt_q  <= '0;
    end else if (clr_i) begin
      act_q  <= 1'b0;
      pend_q <= 1'b0;
      cnt_q  <= '0;
    end else if (!limit) begin
      pend_q <= 1'b0;
      cnt_q  <= '0;
      if (evt_i) act_q <= ~act_q;
    end else if (start_o) begin
      act_q  <= 1'b1;
      pend_q <= 1'b0;
      cnt_q  <= load_o;
    end else if (act_q) begin
      if (ti_tick_i) cnt_q <= cnt_q - 1'b1;
      if (fin_o)     act_q <= 1'b0;
      if (evt_i)     pend_q <= 1'b1;
    end
  end

  assign active_o = act_q;
  assign pend_o   = pend_q;
  assign cnt_o    = cnt_q;
endmodule

// File: rtl/epulse_limiter.sv
module epulse_limiter
  import epl_pkg::*;
#(
  parameter int MAXW_W = 8,
  parameter int INTV_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              evt_i,
  input  logic              samp_tick_i,
  input  logic              cfg_we_i,
  input  logic [MAXW_W-1:0] cfg_maxw_i,
  input  logic [INTV_W-1:0] cfg_intv_i,
  output logic              pulse_no
);
  localparam int CNT_W = MAXW_W + 1;

  logic [MAXW_W-1:0] maxw_w;
  logic [INTV_W-1:0] intv_w;
  epl_mode_e         mode_w;
  logic              half_w;
  logic              ti_tick_w;
  logic              active_w;
  logic              pend_w;
  logic [CNT_W-1:0]  cnt_w;
  logic [CNT_W-1:0]  load_w;
  logic              start_w;
  logic              fin_w;

  epl_cfg_regs #(.MAXW_W(MAXW_W), .INTV_W(INTV_W)) u_cfg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (cfg_we_i),
    .maxw_i (cfg_maxw_i),
    .intv_i (cfg_intv_i),
    .maxw_o (maxw_w),
    .intv_o (intv_w),
    .mode_o (mode_w)
  );

  epl_timebase #(.INTV_W(INTV_W)) u_tb (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .restart_i   (cfg_we_i),
    .samp_tick_i (samp_tick_i),
    .intv_i      (intv_w),
    .ti_tick_o   (ti_tick_w)
  );

  epl_pulse_ctrl #(.MAXW_W(MAXW_W), .CNT_W(CNT_W)) u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (cfg_we_i),
    .evt_i     (evt_i),
    .ti_tick_i (ti_tick_w),
    .mode_i    (mode_w),
    .maxw_i    (maxw_w),
    .active_o  (active_w),
    .pend_o    (pend_w),
    .cnt_o     (cnt_w),
    .load_o    (load_w),
    .start_o   (start_w),
    .fin_o     (fin_w)
  );

  assign half_w   = (mode_w == MODE_HALF);
  assign pulse_no = ~active_w;
endmodule

// File: rtl/epl_checker.sv
module epl_checker #(
  parameter int CNT_W = 9
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             evt_i,
  input logic             samp_tick_i,
  input logic             cfg_we_i,
  input logic             pulse_no,
  input logic             ti_tick,
  input logic             half_mode,
  input logic             active,
  input logic             pend,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] load,
  input logic             start,
  input logic             fin
);
  assert_reset_high_R1: assert property (@(posedge clk_i)
    !rst_ni |=> pulse_no);

  assert_cfg_clears_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_we_i |=> (pulse_no && !pend));

  assert_start_low_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start |=> (!pulse_no && cnt == $past(load)));

  assert_cnt_bound_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active && !half_mode) |-> (cnt != '0 && cnt <= load));

  assert_end_high_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fin |=> pulse_no);

  assert_tick_on_sample_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ti_tick |-> samp_tick_i);

  assert_held_restart_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend && !active && !half_mode && !cfg_we_i) |=> !pulse_no);

  assert_toggle_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (half_mode && evt_i && !cfg_we_i) |=> (pulse_no != $past(pulse_no)));

  assert_half_steady_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (half_mode && !evt_i && !cfg_we_i) |=> $stable(pulse_no));
endmodule

bind epulse_limiter epl_checker #(.CNT_W(CNT_W)) u_epl_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .evt_i       (evt_i),
  .samp_tick_i (samp_tick_i),
  .cfg_we_i    (cfg_we_i),
  .pulse_no    (pulse_no),
  .ti_tick     (ti_tick_w),
  .half_mode   (half_w),
  .active      (active_w),
  .pend        (pend_w),
  .cnt         (cnt_w),
  .load        (load_w),
  .start       (start_w),
  .fin         (fin_w)
);

// File: tb/test_epulse_limiter.sv
module test_epulse_limiter;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       evt = 1'b0;
  logic       samp = 1'b0;
  logic       we = 1'b0;
  logic [7:0] mw = 8'd0;
  logic [7:0] iv = 8'd0;
  logic       pulse_no;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  // reference state, kept in the bench's own terms
  int m_maxw, m_intv, m_left, m_rem;
  bit m_low, m_held;

  always #10 clk = ~clk;

  epulse_limiter i_epulse_limiter (
    .clk_i(clk), .rst_ni(rst_n), .evt_i(evt), .samp_tick_i(samp),
    .cfg_we_i(we), .cfg_maxw_i(mw), .cfg_intv_i(iv), .pulse_no(pulse_no)
  );

  function automatic int units(input int n);
    return n + n + 1;
  endfunction

  task automatic check(input bit act, input bit exp, input string req);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: pulse_no=%0b expected %0b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic model_step(input bit e, input bit t, input bit w,
                            input int nw, input int ni);
    bit tb_tick;
    if (w) begin
      m_maxw = nw; m_intv = ni; m_left = ni;
      m_low = 0; m_held = 0; m_rem = 0;
      return;
    end
    tb_tick = 0;
    if (m_intv == 0) tb_tick = t;
    else if (t) begin
      m_left--;
      if (m_left == 0) begin tb_tick = 1; m_left = m_intv; end
    end
    if (m_maxw == 255) begin
      if (e) m_low = !m_low;
      m_held = 0;
    end else if (!m_low) begin
      if (e || m_held) begin m_low = 1; m_rem = units(m_maxw); m_held = 0; end
    end else begin
      if (tb_tick) begin m_rem--; if (m_rem == 0) m_low = 0; end
      if (e) m_held = 1;
    end
  endtask

  // one clock: inputs applied before the edge, outputs read 2 ns after it
  task automatic cyc(input bit e, input bit t, input bit w = 0,
                     input int nw = 0, input int ni = 0);
    evt = e; samp = t; we = w; mw = 8'(nw); iv = 8'(ni);
    @(posedge clk);
    #2;
    model_step(e, t, w, nw, ni);
    evt = 0; samp = 0; we = 0;
  endtask

  initial begin
    #(20 * 150000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: run did not finish, actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    m_maxw = 255; m_intv = 0; m_left = 0; m_rem = 0; m_low = 0; m_held = 0;
    repeat (3) @(posedge clk);
    #2;
    check(pulse_no, 1'b1, "R1 reset level");
    rst_n = 1'b1;
    cyc(0, 0);
    check(pulse_no, 1'b1, "R1 idle after reset");
    // default width value 255: toggle behaviour
    cyc(1, 0);
    check(pulse_no, 1'b0, "R1 default mode first event");
    for (int i = 0; i < 20; i++) cyc(0, 1);
    check(pulse_no, 1'b0, "R9 ticks ignored");
    cyc(1, 1);
    check(pulse_no, 1'b1, "R9 second event toggles");

    // R4 with N=2 on the sample tick
    cyc(0, 0, 1, 2, 0);
    check(pulse_no, 1'b1, "R2 after write");
    cyc(1, 1);
    check(pulse_no, 1'b0, "R3 start low");
    for (int i = 0; i < 4; i++) begin cyc(0, 1); cyc(0, 0); end
    check(pulse_no, 1'b0, "R4 low before fifth tick");
    cyc(0, 1);
    check(pulse_no, 1'b1, "R5 high after fifth tick");

    // R6: N=1, K=3 -> 9 sample ticks
    cyc(0, 0, 1, 1, 3);
    cyc(1, 0);
    for (int i = 0; i < 8; i++) cyc(0, 1);
    check(pulse_no, 1'b0, "R6 low after 8 sample ticks");
    cyc(0, 1);
    check(pulse_no, 1'b1, "R6 high after 9 sample ticks");

    // R7/R8: N=0, three events during one pulse
    cyc(0, 0, 1, 0, 0);
    cyc(1, 0);
    cyc(1, 0);
    cyc(1, 0);
    cyc(0, 1);
    check(pulse_no, 1'b1, "R7 one high cycle");
    cyc(0, 0);
    check(pulse_no, 1'b0, "R7 held event restarts");
    cyc(0, 1);
    check(pulse_no, 1'b1, "R8 held pulse ends");
    for (int i = 0; i < 5; i++) cyc(0, 0);
    check(pulse_no, 1'b1, "R8 extra events dropped");

    // R7: event in the ending cycle itself
    cyc(1, 0);
    cyc(1, 1);
    check(pulse_no, 1'b1, "R7 end-cycle event gap");
    cyc(0, 0);
    check(pulse_no, 1'b0, "R7 end-cycle event restarts");

    // R2: write cancels active pulse and held event
    cyc(1, 0);
    cyc(0, 0, 1, 4, 0);
    check(pulse_no, 1'b1, "R2 write cancels pulse");
    cyc(0, 0);
    check(pulse_no, 1'b1, "R2 held event cleared");

    // random lockstep against the reference
    begin
      int seed_v;
      int sel;
      seed_v = $urandom(32'h5eed_0042);
      for (int blk = 0; blk < 12; blk++) begin
        int nmw, niv;
        sel = $urandom_range(0, 4);
        nmw = (sel == 0) ? 255 : (sel == 1) ? 0 : (sel == 2) ? 1 : $urandom_range(2, 6);
        niv = ($urandom_range(0, 1) == 0) ? 0 : $urandom_range(1, 4);
        cyc(0, 0, 1, nmw, niv);
        for (int k = 0; k < 300; k++) begin
          cyc(($urandom_range(0, 7) == 0), ($urandom_range(0, 2) == 0));
          check(pulse_no, m_low ? 1'b0 : 1'b1, "R4 random lockstep");
        end
      end
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    done = 1;
    $finish;
  end
endmodule